// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a shared memory that two independent ports reach at the same time. Each clock it compares the ports' addresses and enables. When both ports want the same location, it decides which one came first and drives an active-low busy toward the other. While a port's busy is low, its write strobe to the array is held off. Read paths are never touched.

A port takes part only while its enable and its valid strobe are both high. Such a port is called active. A port is called settled when it was active in the previous cycle with the same address as now.

A collision can begin in two ways. The addresses may already agree when the second enable arrives. Or both ports may already be enabled when one address moves onto the other. In both cases the settled port is the earlier one and wins. If both ports become colliding in the same cycle, that is a tie. A one-bit priority resolves it, so exactly one side loses and the outcome is repeatable in simulation. The decision is combinational from the current inputs and the registered history, so busy shows in the same cycle as the collision. There is no data stream through this block, so every pin is a plain control or status signal without back-pressure.

Top module: `dpc_arbiter`

## Requirements
- R1: After reset, with no collision present, both busy outputs are high (1 = not busy), and each gated write output equals its write request.
- R2: A busy output is never low while the two addresses differ, or while either port is inactive (active means enable = 1 and valid = 1).
- R3: With equal addresses, if one port is active and settled when the other port becomes active, the later port's busy goes low in that same cycle, and the earlier port's busy stays high.
- R4: With both ports active, if one port's address changes to equal the other's settled address, the port that moved gets busy low in that cycle.
- R5: When both ports become colliding in the same cycle, exactly one busy goes low. The first such tie after reset favours port A, so B's busy goes low. Each later tie favours the other port from the tie before.
- R6: Once a winner is chosen, it keeps winning for as long as the collision continues without a break.
- R7: Busy is released (returns high) in the same cycle that the addresses stop matching, or that either port stops being active.
- R8: A port's gated write equals its write request ANDed with its busy output, so a write is suppressed exactly while that port is busy.
- R9: The two busy outputs are never low at the same time.
- R10: The comparison covers every bit of the ADDR_W-bit address. Addresses that differ only in the most significant bit do not collide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_en | input | 1 | Port A enable |
| a_vld | input | 1 | Port A address-valid strobe |
| a_addr | input | ADDR_W | Port A address |
| a_wr | input | 1 | Port A write request |
| b_en | input | 1 | Port B enable |
| b_vld | input | 1 | Port B address-valid strobe |
| b_addr | input | ADDR_W | Port B address |
| b_wr | input | 1 | Port B write request |
| a_busy_n | output | 1 | Port A busy, active low |
| b_busy_n | output | 1 | Port B busy, active low |
| a_wr_go | output | 1 | Port A write strobe passed to the array |
| b_wr_go | output | 1 | Port B write strobe passed to the array |

## Verification
A stale settled flag or a stuck owner register shows at the ports as busy going to the wrong side. It can also show as busy staying low after the addresses part, and this appears in the cycle the collision starts or ends. A tie-priority bit that fails to flip shows only at the second tie, so the bench forces two ties back to back. Random traffic over a tiny address set, including addresses that differ in the top bit, is compared every cycle against a reference model built from the requirements.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_A    = 2'd1,
    OWN_B    = 2'd2
  } own_e;
endpackage

// File: rtl/dpc_port_track.sv
// Remembers one port's activity and address from the previous cycle.
module dpc_port_track #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              vld,
  input  logic [ADDR_W-1:0] addr,
  output logic              act,
  output logic              settled
);
  logic              act_q;
  logic [ADDR_W-1:0] addr_q;

  assign act     = en & vld;
  assign settled = act & act_q & (addr == addr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      act_q  <= act;
      addr_q <= addr;
    end
  end
endmodule

// File: rtl/dpc_addr_cmp.sv
// Full-width equality, built from per-bit agreement.
module dpc_addr_cmp #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] x,
  input  logic [ADDR_W-1:0] y,
  output logic              eq
);
  logic [ADDR_W-1:0] agree;
  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    assign agree[i] = ~(x[i] ^ y[i]);
  end
  assign eq = &agree;
endmodule

// File: rtl/dpc_owner_core.sv
// Chooses and holds the collision winner; toggles tie priority.
module dpc_owner_core
  import dpc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic coll,
  input  logic set_a,
  input  logic set_b,
  output own_e win
);
  own_e own_q;
  logic pri_q;   // 0: A wins next tie, 1: B wins next tie
  logic tie;

  always_comb begin
    tie = 1'b0;
    win = OWN_NONE;
    if (coll) begin
      if (own_q != OWN_NONE)     win = own_q;
      else if (set_a && !set_b)  win = OWN_A;
      else if (set_b && !set_a)  win = OWN_B;
      else begin
        tie = 1'b1;
        win = pri_q ? OWN_B : OWN_A;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q <= OWN_NONE;
      pri_q <= 1'b0;
    end else begin
      own_q <= win;
      if (tie) pri_q <= ~pri_q;
    end
  end

  // R5: a resolved tie flips the preference for the next one
  a_r5_tie_flip: assert property (@(posedge clk) disable iff (!rst_n)
    tie |=> (pri_q != $past(pri_q)));
  // R6: an uninterrupted collision keeps its winner
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (coll && $past(coll) && $past(win) != OWN_NONE) |-> (win == $past(win)));
endmodule

// File: rtl/dpc_arbiter.sv
module dpc_arbiter
  import dpc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a_en,
  input  logic              a_vld,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_wr,
  input  logic              b_en,
  input  logic              b_vld,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_wr,
  output logic              a_busy_n,
  output logic              b_busy_n,
  output logic              a_wr_go,
  output logic              b_wr_go
);
  localparam int NPORT = 2;

  logic [NPORT-1:0]             en_v, vld_v, act_v, set_v;
  logic [NPORT-1:0][ADDR_W-1:0] addr_v;
  logic                         addr_eq, coll;
  own_e                         win;

  assign en_v   = {b_en, a_en};
  assign vld_v  = {b_vld, a_vld};
  assign addr_v = {b_addr, a_addr};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dpc_port_track #(.ADDR_W(ADDR_W)) u_trk (
      .clk(clk), .rst_n(rst_n), .en(en_v[p]), .vld(vld_v[p]),
      .addr(addr_v[p]), .act(act_v[p]), .settled(set_v[p])
    );
  end

  dpc_addr_cmp #(.ADDR_W(ADDR_W)) u_cmp (.x(a_addr), .y(b_addr), .eq(addr_eq));

  assign coll = addr_eq & (&act_v);

  dpc_owner_core u_core (
    .clk(clk), .rst_n(rst_n), .coll(coll),
    .set_a(set_v[0]), .set_b(set_v[1]), .win(win)
  );

  assign a_busy_n = (win != OWN_B);
  assign b_busy_n = (win != OWN_A);
  assign a_wr_go  = a_wr & a_busy_n;
  assign b_wr_go  = b_wr & b_busy_n;

  // R9: never both busy
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    a_busy_n || b_busy_n);
  // R2: busy only with equal addresses
  a_r2_no_busy_on_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
    (a_addr != b_addr) |-> (a_busy_n && b_busy_n));
  // R7: busy released when a port goes inactive
  a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_en && a_vld && b_en && b_vld) |-> (a_busy_n && b_busy_n));
  // R3: a settled port facing a newcomer wins
  a_r3_first_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(a_en && a_vld) && !$past(b_en && b_vld) && $stable(a_addr)
     && a_en && a_vld && b_en && b_vld && a_addr == b_addr) |-> !b_busy_n);
  // R8: write suppressed exactly while busy
  a_r8_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !a_busy_n |-> !a_wr_go);
endmodule

// File: tb/tb_dpc_arbiter.sv
module tb_dpc_arbiter;
  localparam int AW = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic a_en = 0, a_vld = 0, a_wr = 0, b_en = 0, b_vld = 0, b_wr = 0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic a_busy_n, b_busy_n, a_wr_go, b_wr_go;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;   // 125 MHz

  dpc_arbiter #(.ADDR_W(AW)) dut (.*);

  // reference model: 0 none, 1 A, 2 B
  logic          m_act_a = 0, m_act_b = 0, m_pri = 0;
  logic [AW-1:0] m_addr_a = '0, m_addr_b = '0;
  int            m_own = 0;

  function automatic int exp_win(output bit tie);
    bit act_a, act_b, sa, sb;
    act_a = a_en & a_vld; act_b = b_en & b_vld;
    sa = act_a & m_act_a & (a_addr == m_addr_a);
    sb = act_b & m_act_b & (b_addr == m_addr_b);
    tie = 0;
    if (!(act_a && act_b && a_addr == b_addr)) return 0;
    if (m_own != 0) return m_own;
    if (sa && !sb) return 1;
    if (sb && !sa) return 2;
    tie = 1;
    return m_pri ? 2 : 1;
  endfunction

  always @(posedge clk) begin
    bit t; int w;
    if (!rst_n) begin
      m_act_a <= 0; m_act_b <= 0; m_addr_a <= '0; m_addr_b <= '0;
      m_own <= 0; m_pri <= 0;
    end else begin
      w = exp_win(t);
      m_own <= w;
      if (t) m_pri <= ~m_pri;
      m_act_a <= a_en & a_vld; m_act_b <= b_en & b_vld;
      m_addr_a <= a_addr; m_addr_b <= b_addr;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  // drive after falling edge, compare to model before rising edge
  task automatic drv(input logic ae, av, input logic [AW-1:0] aa, input logic aw,
                     input logic be, bv, input logic [AW-1:0] ba, input logic bw,
                     input string tag);
    bit t; int w;
    @(negedge clk);
    a_en = ae; a_vld = av; a_addr = aa; a_wr = aw;
    b_en = be; b_vld = bv; b_addr = ba; b_wr = bw;
    #2;
    w = exp_win(t);
    chk({tag, " a_busy_n"}, a_busy_n, w != 2);
    chk({tag, " b_busy_n"}, b_busy_n, w != 1);
    chk({"R8 a_wr_go ", tag}, a_wr_go, aw & (w != 2));
    chk({"R8 b_wr_go ", tag}, b_wr_go, bw & (w != 1));
    chk({"R9 exclusive ", tag}, a_busy_n | b_busy_n, 1'b1);
  endtask

  task automatic idle();
    drv(0, 0, 0, 0, 0, 0, 0, 0, "idle");
  endtask

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] base;
    void'($urandom(1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    drv(0, 0, 0, 1, 0, 0, 0, 1, "R1");
    chk("R1 a_busy_n lit", a_busy_n, 1'b1);
    chk("R1 a_wr_go lit", a_wr_go, 1'b1);
    // R3 enable order: A first
    drv(1, 1, 16'h0005, 1, 0, 0, 16'h0005, 1, "R3");
    drv(1, 1, 16'h0005, 1, 1, 1, 16'h0005, 1, "R3");
    chk("R3 b_busy_n lit", b_busy_n, 1'b0);
    chk("R8 b_wr_go lit", b_wr_go, 1'b0);
    chk("R3 a_busy_n lit", a_busy_n, 1'b1);
    // R7 winner drops enable
    drv(0, 1, 16'h0005, 0, 1, 1, 16'h0005, 1, "R7");
    chk("R7 b_busy_n lit", b_busy_n, 1'b1);
    idle();
    // R3 mirror: B first
    drv(0, 0, 16'h0022, 0, 1, 1, 16'h0022, 0, "R3");
    drv(1, 1, 16'h0022, 1, 1, 1, 16'h0022, 0, "R3");
    chk("R3 a_busy_n lit", a_busy_n, 1'b0);
    idle();
    // R4 address order: B moves onto A
    drv(1, 1, 16'h0007, 0, 1, 1, 16'h0009, 0, "R4");
    drv(1, 1, 16'h0007, 0, 1, 1, 16'h0007, 0, "R4");
    chk("R4 b_busy_n lit", b_busy_n, 1'b0);
    drv(1, 1, 16'h0007, 0, 1, 1, 16'h0007, 0, "R6");
    chk("R6 b_busy_n held", b_busy_n, 1'b0);
    drv(1, 1, 16'h0007, 0, 1, 1, 16'h0008, 0, "R7");
    chk("R7 b_busy_n released", b_busy_n, 1'b1);
    // R4 mirror: A moves onto B
    drv(1, 1, 16'h0008, 0, 1, 1, 16'h0008, 0, "R4");
    chk("R4 a_busy_n lit", a_busy_n, 1'b0);
    idle();
    // R5 ties: first favours A, next favours B
    drv(1, 1, 16'h0100, 0, 1, 1, 16'h0100, 0, "R5");
    chk("R5 first tie b_busy_n", b_busy_n, 1'b0);
    idle();
    drv(1, 1, 16'h0100, 0, 1, 1, 16'h0100, 0, "R5");
    chk("R5 second tie a_busy_n", a_busy_n, 1'b0);
    idle();
    // R10 differ only in MSB
    drv(1, 1, 16'h8033, 1, 1, 1, 16'h0033, 1, "R10");
    chk("R10 a_busy_n lit", a_busy_n, 1'b1);
    chk("R10 b_busy_n lit", b_busy_n, 1'b1);
    // R2 random traffic over a tiny address set
    base = 16'h1234;
    repeat (3000) begin
      logic [AW-1:0] xa, xb;
      int ra, rb;
      ra = $urandom_range(0, 3); rb = $urandom_range(0, 3);
      xa = (ra == 3) ? (base ^ 16'h8000) : (ra == 2 ? (base ^ 16'h0001) : base);
      xb = (rb == 3) ? (base ^ 16'h8000) : (rb == 2 ? (base ^ 16'h0001) : base);
      drv($urandom_range(0, 5) != 0, $urandom_range(0, 5) != 0, xa, 1'($urandom),
          $urandom_range(0, 5) != 0, $urandom_range(0, 5) != 0, xb, 1'($urandom),
          "R2 random");
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule